// File: doc/BRIEF.md
# Accumulator Arithmetic-Logic Unit

This block is the purely combinational datapath of a small accumulator machine. On every evaluation it takes the present accumulator word, a word fetched from memory and a 6-bit operation code. It returns the word that the accumulator should hold next, together with zero, negative and carry status bits. Storage of the accumulator, memory addressing and instruction sequencing belong to the surrounding controller. That controller registers `acc_out` and the flags on its own clock.

Nine operations are decoded:

- Two-operand: add, subtract, bitwise AND and bitwise OR.
- Accumulator only: bitwise NOT, one-bit shift left, one-bit shift right, increment and decrement. The memory word plays no part in these.

Every other code leaves the accumulator as it is. A single shared adder serves add, subtract, increment and decrement.

Top module: `accum_alu`

## Requirements
- R1: Opcode 6'b000001 gives acc_out = (acc_in + mem_opnd) mod 2^16, and flag_carry is the unsigned carry out of bit 15.
- R2: Opcode 6'b000010 gives acc_out = (acc_in - mem_opnd) mod 2^16, and flag_carry is 1 exactly when acc_in < mem_opnd as unsigned numbers (borrow).
- R3: Opcode 6'b000011 gives acc_in & mem_opnd and opcode 6'b000100 gives acc_in | mem_opnd; flag_carry is 0 for both.
- R4: Opcode 6'b000101 gives ~acc_in with flag_carry 0, and mem_opnd has no effect on any output.
- R5: Opcode 6'b000110 gives acc_in shifted left by one with bit 0 filled with 0; flag_carry equals acc_in[15]; mem_opnd has no effect.
- R6: Opcode 6'b000111 gives acc_in shifted right by one with bit 15 filled with 0; flag_carry equals acc_in[0]; mem_opnd has no effect.
- R7: Opcode 6'b001000 gives (acc_in + 1) mod 2^16; flag_carry is 1 only when acc_in is 16'hFFFF; mem_opnd has no effect.
- R8: Opcode 6'b001001 gives (acc_in - 1) mod 2^16; flag_carry is 1 only when acc_in is 16'h0000 (borrow); mem_opnd has no effect.
- R9: Any opcode not listed in R1 to R8 gives acc_out = acc_in with flag_carry 0.
- R10: flag_zero is 1 exactly when acc_out is 16'h0000, for every opcode.
- R11: flag_neg equals acc_out[15], for every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | 16 | Present accumulator value |
| mem_opnd | input | 16 | Word from memory used by the two-operand operations |
| opcode | input | 6 | Operation code |
| acc_out | output | 16 | Next accumulator value |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Most significant bit of the result |
| flag_carry | output | 1 | Carry, borrow or shifted-out bit |

## Verification
The carry flag and the zero flag can both be raised by the same operation. This is the case whenever a result wraps to zero:

- 16'hFFFF incremented;
- 16'h8000 shifted left;
- 16'h0001 shifted right;
- equal halves whose sum is 2^16.

The opposite case is a borrow that leaves a negative result, such as 16'h0000 decremented or a small value minus a larger one. There the carry and negative flags rise together. Each of these inputs is applied directly. The result word and all three flags are compared against an arithmetic model kept in the bench, so a design that drops one flag while raising the other is caught.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 6;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD  = 6'b000001,
        OPC_SUB  = 6'b000010,
        OPC_AND  = 6'b000011,
        OPC_OR   = 6'b000100,
        OPC_NOT  = 6'b000101,
        OPC_SHL  = 6'b000110,
        OPC_SHR  = 6'b000111,
        OPC_INC  = 6'b001000,
        OPC_DEC  = 6'b001001
    } opc_e;

    // Which functional unit delivers the result
    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_SHIFT = 2'd2,
        UNIT_PASS  = 2'd3
    } unit_e;

    function automatic unit_e unit_of(input logic [OP_W-1:0] op);
        unit_e u;
        case (op)
            OPC_ADD, OPC_SUB, OPC_INC, OPC_DEC: u = UNIT_ARITH;
            OPC_AND, OPC_OR, OPC_NOT:           u = UNIT_LOGIC;
            OPC_SHL, OPC_SHR:                   u = UNIT_SHIFT;
            default:                            u = UNIT_PASS;
        endcase
        return u;
    endfunction

    // Operations whose result never depends on the memory word
    function automatic logic is_unary(input logic [OP_W-1:0] op);
        return (op == OPC_NOT) || (op == OPC_SHL) || (op == OPC_SHR) ||
               (op == OPC_INC) || (op == OPC_DEC);
    endfunction

endpackage

// File: rtl/accum_alu_arith.sv
module accum_alu_arith
    import accum_alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int OPW = OP_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [OPW-1:0] op,
    output logic [W-1:0]   sum,
    output logic           carry
);
    localparam logic [W-1:0] ONE = W'(1);

    logic          use_const;
    logic          invert;
    logic [W-1:0]  b_sel;
    logic [W-1:0]  b_eff;
    logic [W:0]    ext;

    // One adder shared: add, a + ~b + 1, a + 1, a + ~1 + 1
    always_comb begin
        use_const = (op == OPC_INC) || (op == OPC_DEC);
        invert    = (op == OPC_SUB) || (op == OPC_DEC);
        b_sel     = use_const ? ONE : b;
        b_eff     = invert ? ~b_sel : b_sel;
        ext       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, invert};
        sum       = ext[W-1:0];
        // Subtract forms report borrow: inverted carry out
        carry     = invert ? ~ext[W] : ext[W];
    end
endmodule

// File: rtl/accum_alu_logic.sv
module accum_alu_logic
    import accum_alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int OPW = OP_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [OPW-1:0] op,
    output logic [W-1:0]   res
);
    always_comb begin
        case (op)
            OPC_AND: res = a & b;
            OPC_OR:  res = a | b;
            default: res = ~a;
        endcase
    end
endmodule

// File: rtl/accum_alu_shift.sv
module accum_alu_shift
    import accum_alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int OPW = OP_W
) (
    input  logic [W-1:0]   a,
    input  logic [OPW-1:0] op,
    output logic [W-1:0]   res,
    output logic           out_bit
);
    logic left;

    always_comb begin
        left    = (op == OPC_SHL);
        res     = left ? {a[W-2:0], 1'b0} : {1'b0, a[W-1:1]};
        out_bit = left ? a[W-1] : a[0];
    end
endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accum_alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int OPW = OP_W
) (
    input  logic [W-1:0]   acc_in,
    input  logic [W-1:0]   mem_opnd,
    input  logic [OPW-1:0] opcode,
    output logic [W-1:0]   acc_out,
    output logic           flag_zero,
    output logic           flag_neg,
    output logic           flag_carry
);
    typedef struct packed {
        logic [W-1:0] value;
        logic         carry;
    } res_t;

    logic [W-1:0] ar_sum;
    logic         ar_c;
    logic [W-1:0] lg_res;
    logic [W-1:0] sh_res;
    logic         sh_c;
    res_t         sel;
    unit_e        unit;

    accum_alu_arith #(.W(W), .OPW(OPW)) u_arith (
        .a(acc_in), .b(mem_opnd), .op(opcode), .sum(ar_sum), .carry(ar_c)
    );

    accum_alu_logic #(.W(W), .OPW(OPW)) u_logic (
        .a(acc_in), .b(mem_opnd), .op(opcode), .res(lg_res)
    );

    accum_alu_shift #(.W(W), .OPW(OPW)) u_shift (
        .a(acc_in), .op(opcode), .res(sh_res), .out_bit(sh_c)
    );

    always_comb begin
        unit = unit_of(opcode);
        case (unit)
            UNIT_ARITH: sel = '{value: ar_sum, carry: ar_c};
            UNIT_LOGIC: sel = '{value: lg_res, carry: 1'b0};
            UNIT_SHIFT: sel = '{value: sh_res, carry: sh_c};
            default:    sel = '{value: acc_in, carry: 1'b0};
        endcase
    end

    assign acc_out    = sel.value;
    assign flag_carry = sel.carry;
    assign flag_zero  = (sel.value == '0);
    assign flag_neg   = sel.value[W-1];
endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk
    import accum_alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int OPW = OP_W
) (
    input logic [W-1:0]   acc_in,
    input logic [W-1:0]   mem_opnd,
    input logic [OPW-1:0] opcode,
    input logic [W-1:0]   acc_out,
    input logic           flag_zero,
    input logic           flag_neg,
    input logic           flag_carry
);
    logic known;

    always_comb begin
        known = !$isunknown({acc_in, mem_opnd, opcode});
        if (known) begin
            // R10
            zero_flag_chk: assert (flag_zero == (acc_out == '0));
            // R11
            neg_flag_chk: assert (flag_neg == acc_out[W-1]);
            if (opcode == OPC_ADD) begin
                // R1
                add_wide_chk: assert ({flag_carry, acc_out} ==
                                      ({1'b0, acc_in} + {1'b0, mem_opnd}));
            end
            if (opcode == OPC_SUB) begin
                // R2
                sub_borrow_chk: assert (flag_carry == (acc_in < mem_opnd));
            end
            if (opcode == OPC_AND || opcode == OPC_OR || opcode == OPC_NOT) begin
                // R3
                logic_carry_chk: assert (!flag_carry);
            end
            if (opcode == OPC_INC) begin
                // R7
                inc_wrap_chk: assert (flag_carry == (acc_in == '1));
            end
            if (opcode == OPC_DEC) begin
                // R8
                dec_wrap_chk: assert (flag_carry == (acc_in == '0));
            end
            if (unit_of(opcode) == UNIT_PASS) begin
                // R9
                pass_hold_chk: assert (acc_out == acc_in && !flag_carry);
            end
            if (is_unary(opcode)) begin
                // R4
                unary_width_chk: assert (!$isunknown({acc_out, flag_carry}));
            end
        end
    end
endmodule

bind accum_alu accum_alu_chk #(.W(W), .OPW(OPW)) u_chk (
    .acc_in(acc_in), .mem_opnd(mem_opnd), .opcode(opcode),
    .acc_out(acc_out), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .flag_carry(flag_carry)
);

// File: tb/accum_alu_test.sv
module accum_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] acc_in = '0;
    logic [15:0] mem_opnd = '0;
    logic [5:0]  opcode = '0;
    logic [15:0] acc_out;
    logic        flag_zero, flag_neg, flag_carry;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    accum_alu uut (
        .acc_in(acc_in), .mem_opnd(mem_opnd), .opcode(opcode),
        .acc_out(acc_out), .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_carry(flag_carry)
    );

    // Independent model from the requirement list
    task automatic model(input logic [5:0] op, input logic [15:0] a,
                         input logic [15:0] b, output logic [15:0] r,
                         output logic c);
        logic [16:0] t;
        c = 1'b0;
        case (op)
            6'b000001: begin t = a + b; r = t[15:0]; c = t[16]; end
            6'b000010: begin r = a - b; c = (a < b); end
            6'b000011: r = a & b;
            6'b000100: r = a | b;
            6'b000101: r = ~a;
            6'b000110: begin r = a << 1; c = a[15]; end
            6'b000111: begin r = a >> 1; c = a[0]; end
            6'b001000: begin r = a + 16'd1; c = (a == 16'hFFFF); end
            6'b001001: begin r = a - 16'd1; c = (a == 16'h0000); end
            default:   r = a;
        endcase
    endtask

    task automatic apply(input logic [5:0] op, input logic [15:0] a,
                         input logic [15:0] b);
        @(posedge clk);
        opcode = op; acc_in = a; mem_opnd = b;
        @(negedge clk);
    endtask

    task automatic compare(input string tag, input logic [16:0] got,
                           input logic [16:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Applies a case and checks value and all three flags
    task automatic run(input string tag, input logic [5:0] op,
                       input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r;
        logic c;
        apply(op, a, b);
        model(op, a, b, r, c);
        compare(tag, {acc_out, flag_carry}, {r, c});
        compare({tag, " R10 zero"}, {16'd0, flag_zero}, {16'd0, r == 16'd0});
        compare({tag, " R11 neg"}, {16'd0, flag_neg}, {16'd0, r[15]});
    endtask

    task automatic t_reset;
        apply(6'b000000, 16'h0000, 16'h0000);
        compare("reset R9", {acc_out, flag_carry}, 17'd0);
        compare("reset R10", {16'd0, flag_zero}, 17'd1);
    endtask

    task automatic t_add;
        run("R1 plain", 6'b000001, 16'h1234, 16'h0F0F);
        run("R1 wrap zero", 6'b000001, 16'h8000, 16'h8000);
        run("R1 wrap carry", 6'b000001, 16'hFFFF, 16'h0002);
        run("R1 neg", 6'b000001, 16'h7FFF, 16'h0001);
    endtask

    task automatic t_sub;
        run("R2 plain", 6'b000010, 16'h5000, 16'h1000);
        run("R2 equal", 6'b000010, 16'hABCD, 16'hABCD);
        run("R2 borrow", 6'b000010, 16'h0003, 16'h0005);
    endtask

    task automatic t_logic;
        run("R3 and", 6'b000011, 16'hF0F0, 16'h3C3C);
        run("R3 and zero", 6'b000011, 16'hAAAA, 16'h5555);
        run("R3 or", 6'b000100, 16'h8001, 16'h0240);
    endtask

    task automatic t_not;
        logic [16:0] first;
        run("R4 not", 6'b000101, 16'h00FF, 16'h1234);
        first = {acc_out, flag_carry};
        apply(6'b000101, 16'h00FF, 16'hFFFF);
        compare("R4 operand ignored", {acc_out, flag_carry}, first);
        run("R4 not all ones", 6'b000101, 16'hFFFF, 16'h0000);
    endtask

    task automatic t_shift;
        run("R5 shl", 6'b000110, 16'h4001, 16'hFFFF);
        run("R5 shl out zero", 6'b000110, 16'h8000, 16'h1111);
        run("R6 shr", 6'b000111, 16'h8002, 16'hFFFF);
        run("R6 shr out zero", 6'b000111, 16'h0001, 16'h2222);
    endtask

    task automatic t_incdec;
        run("R7 inc", 6'b001000, 16'h00FF, 16'hFFFF);
        run("R7 inc wrap", 6'b001000, 16'hFFFF, 16'h0000);
        run("R8 dec", 6'b001001, 16'h0100, 16'hFFFF);
        run("R8 dec wrap", 6'b001001, 16'h0000, 16'h0000);
        run("R8 dec to zero", 6'b001001, 16'h0001, 16'h7777);
    endtask

    task automatic t_unknown;
        run("R9 code0", 6'b000000, 16'h9ABC, 16'h1111);
        run("R9 code10", 6'b001010, 16'hFFFF, 16'hFFFF);
        run("R9 code63", 6'b111111, 16'h1234, 16'h4321);
        run("R9 code33", 6'b100001, 16'h0F00, 16'h0100);
    endtask

    // Pseudo-random sweep across every code with an LFSR
    task automatic t_sweep;
        logic [31:0] s = 32'hACE1_1234;
        for (int i = 0; i < 400; i++) begin
            s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
            run("R1-R9 sweep", 6'(i % 12), s[15:0], s[31:16]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_not();
        t_shift();
        t_incdec();
        t_unknown();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule